// File: doc/BRIEF.md
# Register-Windowed Command Data FIFO Pair

This block sits between a 32-bit register bus and a serial flash engine and carries the data of software-started transfers. Two 64-bit-wide FIFOs are provided. The receive FIFO is filled by the engine and emptied by software. The transmit FIFO is filled by software and emptied by the engine. Software never sees a FIFO pointer directly. It looks at one chunk through a two-word register window. When it has finished with that chunk, it writes a one to a status flag, and that write moves the pointer.

On the receive side, software reads the two window words of the oldest entry and then writes 1 to the receive flag to release the entry. On the transmit side, software writes the two window words into a staging register and then writes 1 to the transmit flag, which commits the staged chunk as one entry. A transfer that ends with fewer than eight bytes is still moved as a full chunk. Each FIFO can be flushed through its own control register. A status register reports the fill level of the FIFO and a 16-bit count of chunks moved by software.

Top module: `cmdfifo_window`

## Requirements
- R1: After reset both FIFOs are empty. The flag register (offset 0x00) reads 0x2: bit 0 (receive data available) is 0 and bit 1 (transmit room) is 1. Both status registers read 0, `eng_rx_ready` is 1 and `eng_tx_valid` is 0.
- R2: Reading offset 0x20 returns bits [31:0] of the oldest receive entry and reading offset 0x24 returns bits [63:32]. Reading either word does not change the FIFO.
- R3: Flag bit 0 reads 1 exactly when the receive fill is at least one. Writing 1 to bit 0 at offset 0x00 removes the oldest receive entry, and the next entry then appears in the window.
- R4: Writing 1 to flag bit 0 while the receive FIFO is empty changes neither the fill nor the chunk counter.
- R5: Writes to offsets 0x30 (bits [31:0]) and 0x34 (bits [63:32]) load the transmit staging register. Writing 1 to flag bit 1 pushes the staged 64-bit value as one entry and clears the staging register to zero. Flag bit 1 reads 1 exactly when the transmit fill is below TX_DEPTH.
- R6: A tail chunk written only at offset 0x30 and then committed is pushed whole, with bits [63:32] equal to zero.
- R7: Writing 1 to flag bit 1 while the transmit FIFO is full pushes nothing and leaves the fill and the chunk counter unchanged.
- R8: The receive FIFO holds RX_DEPTH (default 64) entries. `eng_rx_ready` is 1 exactly when the FIFO is not full, and entries come out in the order they were accepted.
- R9: The transmit FIFO holds TX_DEPTH (default 128) entries. `eng_tx_valid` is 1 exactly when the FIFO is not empty, `eng_tx_data` is the oldest entry, and `eng_tx_pop` removes that entry.
- R10: Writing 1 to bit 0 of offset 0x04 empties the receive FIFO, and writing 1 to bit 0 of offset 0x08 empties the transmit FIFO. A flush leaves the chunk counters as they were.
- R11: Offset 0x0C reads {receive chunk count[15:0], receive fill[15:0]} and offset 0x10 reads the same pair for transmit. Each count increases by one for every flag write that actually moves a pointer.
- R12: An engine transfer and a software flag advance on the same FIFO in the same cycle both take effect, and the fill stays the same.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Register byte offset |
| bus_wr | input | 1 | Register write strobe |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data, combinational on bus_addr |
| eng_rx_valid | input | 1 | Engine offers a receive entry |
| eng_rx_data | input | 64 | Receive entry from the engine |
| eng_rx_ready | output | 1 | Receive FIFO can accept an entry |
| eng_tx_valid | output | 1 | Transmit entry available to the engine |
| eng_tx_data | output | 64 | Oldest transmit entry |
| eng_tx_pop | input | 1 | Engine consumes the oldest transmit entry |

## Verification
The receive FIFO is filled to capacity with an index-derived pattern. The bench then drains it one chunk at a time, reading each window word twice, which separates a read-side pointer move from a flag-driven one and exposes any reordering. The transmit FIFO is filled to its limit in the same way and emptied through the engine port, with a commit attempted while it is full. A commit made after writing only the low word shows whether the staging register is cleared after each push. Flushes are tried on partly filled FIFOs, and same-cycle push and advance pairs show whether either event is lost.

// File: rtl/cmdfifo_pkg.sv
package cmdfifo_pkg;
  localparam int DATA_W  = 64;
  localparam int WORD_W  = 32;
  localparam int WORDS   = DATA_W / WORD_W;
  localparam int TALLY_W = 16;

  localparam logic [7:0] A_FLAGS   = 8'h00;
  localparam logic [7:0] A_RX_CTRL = 8'h04;
  localparam logic [7:0] A_TX_CTRL = 8'h08;
  localparam logic [7:0] A_RX_STAT = 8'h0C;
  localparam logic [7:0] A_TX_STAT = 8'h10;
  localparam logic [7:0] A_RX_WIN  = 8'h20;
  localparam logic [7:0] A_TX_WIN  = 8'h30;

  localparam int FLAG_RX    = 0;
  localparam int FLAG_TX    = 1;
  localparam int CTRL_FLUSH = 0;

  typedef logic [DATA_W-1:0] chunk_t;

  // Status word: software chunk count above, fill level below.
  function automatic logic [31:0] pack_status(input logic [TALLY_W-1:0] tally,
                                              input logic [15:0] fill);
    return {tally, fill};
  endfunction

  // True when addr falls inside the two-word window starting at base.
  function automatic logic win_hit(input logic [7:0] addr, input logic [7:0] base);
    return (addr[7:3] == base[7:3]) && (addr[1:0] == 2'b00);
  endfunction

  function automatic logic [WORD_W-1:0] chunk_word(input chunk_t c, input logic idx);
    return idx ? c[DATA_W-1:WORD_W] : c[WORD_W-1:0];
  endfunction
endpackage

// File: rtl/cmdfifo_store.sv
module cmdfifo_store
  import cmdfifo_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int PW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          push,
  input  chunk_t        push_data,
  input  logic          pop,
  output chunk_t        head,
  output logic [CW-1:0] fill,
  output logic          full,
  output logic          empty,
  output logic          push_fire,
  output logic          pop_fire
);
  logic [PW-1:0] wptr, rptr;
  chunk_t        mem [DEPTH];

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full      = (fill == CW'(DEPTH));
  assign empty     = (fill == '0);
  assign push_fire = push && !full && !flush;
  assign pop_fire  = pop && !empty && !flush;
  assign head      = mem[rptr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr <= '0;
      rptr <= '0;
      fill <= '0;
    end else if (flush) begin
      wptr <= '0;
      rptr <= '0;
      fill <= '0;
    end else begin
      if (push_fire) wptr <= bump(wptr);
      if (pop_fire)  rptr <= bump(rptr);
      if (push_fire && !pop_fire)      fill <= fill + 1'b1;
      else if (pop_fire && !push_fire) fill <= fill - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (push_fire) mem[wptr] <= push_data;
  end

  // R8/R9: a full FIFO refuses pushes.
  p_full_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !pop && !flush) |=> (fill == $past(fill)));
  // R4: popping an empty FIFO does nothing.
  p_empty_pop_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && pop && !push && !flush) |=> empty);
  // R10: flush empties the FIFO.
  p_flush_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> empty);
  // R12: push and pop together keep the fill.
  p_both_fire_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (push_fire && pop_fire) |=> (fill == $past(fill)));
endmodule

// File: rtl/cmdfifo_stage.sv
module cmdfifo_stage
  import cmdfifo_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORDS-1:0]  word_we,
  input  logic [WORD_W-1:0] wdata,
  input  logic              commit,
  output chunk_t            stage
);
  logic [WORD_W-1:0] words [WORDS];

  for (genvar w = 0; w < WORDS; w++) begin : g_word
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          words[w] <= '0;
      else if (commit)     words[w] <= '0;
      else if (word_we[w]) words[w] <= wdata;
    end
    assign stage[w*WORD_W +: WORD_W] = words[w];
  end

  // R6: the staging register is empty after each committed chunk.
  p_stage_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> (stage == '0));
endmodule

// File: rtl/cmdfifo_tally.sv
module cmdfifo_tally #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         step,
  output logic [W-1:0] value
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    value <= '0;
    else if (step) value <= value + 1'b1;
  end

  // R11: one count per effective advance.
  p_tally_step_r11: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> (value == $past(value) + 1'b1));
  p_tally_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !step |=> (value == $past(value)));
endmodule

// File: rtl/cmdfifo_window.sv
module cmdfifo_window
  import cmdfifo_pkg::*;
#(
  parameter int RX_DEPTH = 64,
  parameter int TX_DEPTH = 128
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [7:0]  bus_addr,
  input  logic        bus_wr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  input  logic        eng_rx_valid,
  input  logic [63:0] eng_rx_data,
  output logic        eng_rx_ready,
  output logic        eng_tx_valid,
  output logic [63:0] eng_tx_data,
  input  logic        eng_tx_pop
);
  localparam int RX_CW = $clog2(RX_DEPTH + 1);
  localparam int TX_CW = $clog2(TX_DEPTH + 1);

  // Named internal events.
  logic flag_wr, rx_adv_req, tx_commit_req, rx_flush, tx_flush;
  logic rx_push_fire, rx_pop_fire, tx_push_fire, tx_pop_fire;
  logic rx_full, rx_empty, tx_full, tx_empty;
  logic rx_avail, tx_room;
  logic [RX_CW-1:0] rx_fill;
  logic [TX_CW-1:0] tx_fill;
  logic [TALLY_W-1:0] rx_tally, tx_tally;
  chunk_t rx_head, tx_head, tx_stage;
  logic [WORDS-1:0] tx_word_we;

  assign flag_wr       = bus_wr && (bus_addr == A_FLAGS);
  assign rx_adv_req    = flag_wr && bus_wdata[FLAG_RX];
  assign tx_commit_req = flag_wr && bus_wdata[FLAG_TX];
  assign rx_flush      = bus_wr && (bus_addr == A_RX_CTRL) && bus_wdata[CTRL_FLUSH];
  assign tx_flush      = bus_wr && (bus_addr == A_TX_CTRL) && bus_wdata[CTRL_FLUSH];

  for (genvar w = 0; w < WORDS; w++) begin : g_txwe
    assign tx_word_we[w] = bus_wr && win_hit(bus_addr, A_TX_WIN) && (bus_addr[2] == w[0]);
  end

  cmdfifo_store #(.DEPTH(RX_DEPTH)) u_rx (
    .clk, .rst_n, .flush(rx_flush),
    .push(eng_rx_valid), .push_data(eng_rx_data),
    .pop(rx_adv_req), .head(rx_head), .fill(rx_fill),
    .full(rx_full), .empty(rx_empty),
    .push_fire(rx_push_fire), .pop_fire(rx_pop_fire)
  );

  cmdfifo_store #(.DEPTH(TX_DEPTH)) u_tx (
    .clk, .rst_n, .flush(tx_flush),
    .push(tx_commit_req), .push_data(tx_stage),
    .pop(eng_tx_pop), .head(tx_head), .fill(tx_fill),
    .full(tx_full), .empty(tx_empty),
    .push_fire(tx_push_fire), .pop_fire(tx_pop_fire)
  );

  cmdfifo_stage u_stage (
    .clk, .rst_n, .word_we(tx_word_we), .wdata(bus_wdata),
    .commit(tx_push_fire), .stage(tx_stage)
  );

  cmdfifo_tally #(.W(TALLY_W)) u_rx_tally (
    .clk, .rst_n, .step(rx_pop_fire), .value(rx_tally)
  );
  cmdfifo_tally #(.W(TALLY_W)) u_tx_tally (
    .clk, .rst_n, .step(tx_push_fire), .value(tx_tally)
  );

  assign rx_avail     = !rx_empty;
  assign tx_room      = !tx_full;
  assign eng_rx_ready = !rx_full;
  assign eng_tx_valid = !tx_empty;
  assign eng_tx_data  = tx_head;

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == A_FLAGS) begin
      bus_rdata[FLAG_RX] = rx_avail;
      bus_rdata[FLAG_TX] = tx_room;
    end else if (bus_addr == A_RX_STAT) begin
      bus_rdata = pack_status(rx_tally, 16'(rx_fill));
    end else if (bus_addr == A_TX_STAT) begin
      bus_rdata = pack_status(tx_tally, 16'(tx_fill));
    end else if (win_hit(bus_addr, A_RX_WIN)) begin
      bus_rdata = chunk_word(rx_head, bus_addr[2]);
    end
  end

  // R3: a granted receive advance lowers the fill by one.
  p_rx_adv_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_adv_req && !rx_empty && !eng_rx_valid && !rx_flush)
      |=> (rx_fill == $past(rx_fill) - 1'b1));
  // R5: a granted commit raises the transmit fill by one.
  p_tx_commit_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_commit_req && !tx_full && !eng_tx_pop && !tx_flush)
      |=> (tx_fill == $past(tx_fill) + 1'b1));
  // R7: a commit into a full FIFO leaves the counter alone.
  p_tx_full_commit_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_commit_req && tx_full) |=> (tx_tally == $past(tx_tally)));
endmodule

// File: tb/cmdfifo_window_tb.sv
`timescale 1ns/1ps
module cmdfifo_window_tb;
  localparam int RXD = 64;
  localparam int TXD = 128;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        eng_rx_valid = 1'b0;
  logic [63:0] eng_rx_data = '0;
  logic        eng_rx_ready;
  logic        eng_tx_valid;
  logic [63:0] eng_tx_data;
  logic        eng_tx_pop = 1'b0;

  int tests = 0;
  int fails = 0;
  int rx_pops = 0;
  int tx_pushes = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  cmdfifo_window #(.RX_DEPTH(RXD), .TX_DEPTH(TXD)) u_dut (.*);

  function automatic logic [63:0] rxpat(input int i);
    return {32'hA500_0000 | 32'(i), (32'(i) * 32'h0103_0507) ^ 32'h5A5A_5A5A};
  endfunction
  function automatic logic [63:0] txpat(input int i);
    return {32'h7E00_0000 + 32'(i) * 3, 32'h0F0F_0000 ^ 32'(i)};
  endfunction

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wr = 1'b1; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic eng_push(input logic [63:0] d);
    @(negedge clk);
    eng_rx_valid = 1'b1; eng_rx_data = d;
    @(negedge clk);
    eng_rx_valid = 1'b0;
  endtask

  task automatic eng_pop();
    @(negedge clk);
    eng_tx_pop = 1'b1;
    @(negedge clk);
    eng_tx_pop = 1'b0;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] r, r2;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    bus_read(8'h00, r); check("R1 flags", r, 64'h2);
    bus_read(8'h0C, r); check("R1 rx status", r, 0);
    bus_read(8'h10, r); check("R1 tx status", r, 0);
    check("R1 tx valid", eng_tx_valid, 0);
    check("R1 rx ready", eng_rx_ready, 1);

    // R4: advance on empty receive FIFO
    bus_write(8'h00, 32'h1);
    bus_read(8'h0C, r); check("R4 empty advance", r, 0);

    // R8: fill receive FIFO to capacity
    for (int i = 0; i < RXD; i++) begin
      if (eng_rx_ready !== 1'b1) check("R8 ready before full", eng_rx_ready, 1);
      eng_push(rxpat(i));
    end
    check("R8 ready at full", eng_rx_ready, 0);
    bus_read(8'h0C, r); check("R8 fill at full", r, RXD);
    eng_push(64'hDEAD_BEEF_DEAD_BEEF);
    bus_read(8'h0C, r); check("R8 push when full", r, RXD);
    bus_read(8'h00, r); check("R3 avail at full", r[0], 1);

    // R2/R3/R11: drain through the window
    for (int i = 0; i < RXD; i++) begin
      bus_read(8'h20, r);  check("R2 low word", r, rxpat(i) & 64'hFFFF_FFFF);
      bus_read(8'h24, r);  check("R2 high word", r, rxpat(i) >> 32);
      bus_read(8'h20, r2); check("R2 reread stable", r2, rxpat(i) & 64'hFFFF_FFFF);
      bus_write(8'h00, 32'h1);
      rx_pops++;
      bus_read(8'h0C, r);
      check("R11 rx status", r, {16'(rx_pops), 16'(RXD - 1 - i)});
    end
    bus_read(8'h00, r); check("R3 avail empty", r[0], 0);
    bus_write(8'h00, 32'h1);
    bus_read(8'h0C, r); check("R4 advance after drain", r, {16'(rx_pops), 16'd0});

    // R5/R9: fill transmit FIFO through the staging register
    for (int i = 0; i < TXD; i++) begin
      bus_read(8'h00, r);
      if (r[1] !== 1'b1) check("R5 room before full", r[1], 1);
      bus_write(8'h30, txpat(i)[31:0]);
      bus_write(8'h34, txpat(i)[63:32]);
      bus_write(8'h00, 32'h2);
      tx_pushes++;
    end
    bus_read(8'h00, r); check("R5 room at full", r[1], 0);
    bus_read(8'h10, r); check("R9 tx status full", r, {16'(tx_pushes), 16'(TXD)});

    // R7: commit into full FIFO
    bus_write(8'h30, 32'h0000_1234);
    bus_write(8'h00, 32'h2);
    bus_read(8'h10, r); check("R7 full commit ignored", r, {16'(tx_pushes), 16'(TXD)});

    // R9: engine drains in order
    for (int i = 0; i < TXD; i++) begin
      #1;
      check("R9 tx valid", eng_tx_valid, 1);
      check("R9 tx data", eng_tx_data, txpat(i));
      eng_pop();
    end
    #1 check("R9 tx empty", eng_tx_valid, 0);

    // R6: tail chunk with only the low word written
    bus_write(8'h30, 32'h0000_BEEF);
    bus_write(8'h00, 32'h2);
    tx_pushes++;
    #1 check("R6 tail chunk", eng_tx_data, 64'h0000_0000_0000_BEEF);
    bus_read(8'h10, r); check("R11 tx status", r, {16'(tx_pushes), 16'd1});

    // R10: flushes
    bus_write(8'h08, 32'h1);
    bus_read(8'h10, r); check("R10 tx flush", r, {16'(tx_pushes), 16'd0});
    #1 check("R10 tx valid after flush", eng_tx_valid, 0);
    for (int i = 0; i < 3; i++) eng_push(rxpat(100 + i));
    bus_write(8'h04, 32'h1);
    bus_read(8'h0C, r); check("R10 rx flush", r, {16'(rx_pops), 16'd0});
    bus_read(8'h00, r); check("R10 flags after flush", r, 64'h2);

    // R12: simultaneous push and advance on receive side
    eng_push(rxpat(200));
    eng_push(rxpat(201));
    @(negedge clk);
    eng_rx_valid = 1'b1; eng_rx_data = rxpat(202);
    bus_addr = 8'h00; bus_wr = 1'b1; bus_wdata = 32'h1;
    @(negedge clk);
    eng_rx_valid = 1'b0; bus_wr = 1'b0;
    rx_pops++;
    bus_read(8'h0C, r); check("R12 rx fill kept", r, {16'(rx_pops), 16'd2});
    bus_read(8'h20, r); check("R12 rx head moved", r, rxpat(201) & 64'hFFFF_FFFF);

    // R12: simultaneous commit and engine pop on transmit side
    bus_write(8'h30, txpat(300)[31:0]);
    bus_write(8'h34, txpat(300)[63:32]);
    bus_write(8'h00, 32'h2);
    tx_pushes++;
    bus_write(8'h30, txpat(301)[31:0]);
    bus_write(8'h34, txpat(301)[63:32]);
    @(negedge clk);
    eng_tx_pop = 1'b1;
    bus_addr = 8'h00; bus_wr = 1'b1; bus_wdata = 32'h2;
    @(negedge clk);
    eng_tx_pop = 1'b0; bus_wr = 1'b0;
    tx_pushes++;
    bus_read(8'h10, r); check("R12 tx fill kept", r, {16'(tx_pushes), 16'd1});
    #1 check("R12 tx head moved", eng_tx_data, txpat(301));

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule